// File: doc/BRIEF.md
# Halfword Code-Fetch Flash Buffer

This block joins a processor that fetches 16-bit instructions to a flash array that delivers aligned 32-bit words after a programmable number of wait cycles. It keeps the last fetched word in a one-word buffer. When the processor steps on to the other half of that word, the halfword comes straight from the buffer. At the moment the upper half of a word is handed over, the block also starts the flash read of the following word. Straight-line code therefore reaches the next word already in flight or already present.

The processor side is a valid/ready handshake: the processor holds `req_valid` and `req_addr` steady until `req_ready` is seen. The flash side is a start strobe with a word address. The flash places the word on `fl_data` in the cycle that lies exactly the wait count after the start cycle. A request that does not continue the sequence throws away the held word and any read in flight, and the block starts again with a full-latency read.

Top module: `hw_fetch_buf`

## Requirements
- R1: After reset the buffer holds nothing usable and no read is outstanding. With `req_valid` low, `req_ready` and `fl_start` stay low, and the first request after reset is treated as a miss even if it targets an upper halfword.
- R2: The word address is `req_addr[ADDR_W-1:2]` and `req_addr[0]` is ignored. `req_addr[1]` = 0 returns bits 15:0 of the word and `req_addr[1]` = 1 returns bits 31:16.
- R3: A miss drives `fl_start` = 1 with `fl_addr` equal to the requested word in the same cycle the request appears. A miss is any request that is not the last served halfword address plus one halfword. `req_ready` then rises exactly W cycles later, giving W stall cycles.
- R4: A sequential request to the upper halfword of the word just used is answered in the cycle it appears, from the buffer, without a flash read of that word.
- R5: In every cycle that delivers an upper halfword, the block drives `fl_start` = 1 with `fl_addr` equal to that word plus one (prefetch).
- R6: A sequential request to the lower halfword of the prefetched word completes at the later of its own first cycle and the prefetch start cycle plus W. In a back-to-back stream this gives 0 stalls for every fetch after the first with W = 1, stalls alternating 1,0 with W = 2, and stalls alternating 2,0 with W = 3.
- R7: A non-sequential request discards both the buffered word and any read in flight, including a request that repeats an address whose word is buffered. It pays the full W.
- R8: W is taken from the 2-bit `cfg_wait` when a read is started, with value 0 treated as 1. It is held for that read, so changing `cfg_wait` while a read is outstanding does not alter that read's latency.
- R9: A prefetch that completes while the processor is idle is kept. A later sequential lower-halfword request is then answered in its first cycle.
- R10: `req_ready` is high only while `req_valid` is high, and `req_data` in that cycle is the selected half of the addressed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_wait | input | 2 | Flash wait count, 0 behaves as 1 |
| req_valid | input | 1 | Processor fetch request present |
| req_addr | input | ADDR_W | Byte address of the fetch |
| req_ready | output | 1 | Fetch completes this cycle |
| req_data | output | 16 | Fetched halfword |
| fl_start | output | 1 | Start a flash word read |
| fl_addr | output | ADDR_W-2 | Word address of the read |
| fl_data | input | 32 | Word from flash, valid W cycles after start |

## Verification
The bench builds the block with the default 16-bit byte address. That address space is wide enough to run separate code regions for each wait setting without aliasing, and to give every word a distinct data pattern. A flash model returns data only in the exact cycle the latency allows and drives a poison value at every other time. This makes early or late capture visible. All three legal wait settings and the zero setting can be reached at run time, so the alternating stall pattern, a jump over a prefetch in flight and a wait change during an outstanding read are each driven with cycle-exact expectations.

// File: rtl/hwfb_pkg.sv
package hwfb_pkg;

    localparam int WAIT_W = 2;
    localparam int HALF_W = 16;
    localparam int WORD_W = 2 * HALF_W;

    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_HIT   = 2'd1,
        ACT_STALL = 2'd2,
        ACT_MISS  = 2'd3
    } act_e;

    typedef struct packed {
        logic              upper;
        logic [HALF_W-1:0] half;
    } half_sel_t;

    function automatic logic [WAIT_W-1:0] eff_wait(input logic [WAIT_W-1:0] c);
        return (c == '0) ? WAIT_W'(1) : c;
    endfunction

    function automatic logic [HALF_W-1:0] pick_half(input logic [WORD_W-1:0] w,
                                                    input logic upper);
        return upper ? w[WORD_W-1:HALF_W] : w[HALF_W-1:0];
    endfunction

endpackage

// File: rtl/hwfb_seq_track.sv
module hwfb_seq_track #(
    parameter int HW_W = 15
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            served,
    input  logic [HW_W-1:0] req_hw,
    output logic            seq
);
    logic [HW_W-1:0] last_hw_q;
    logic            last_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_hw_q <= '0;
            last_v_q  <= 1'b0;
        end else if (served) begin
            last_hw_q <= req_hw;
            last_v_q  <= 1'b1;
        end
    end

    assign seq = last_v_q && (req_hw == last_hw_q + HW_W'(1));

    p_no_seq_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !last_v_q);

endmodule

// File: rtl/hwfb_read_ctrl.sv
module hwfb_read_ctrl import hwfb_pkg::*; #(
    parameter int WA_W = 14,
    parameter int HW_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              launch,
    input  logic [WA_W-1:0]   launch_addr,
    input  logic              launch_pf,
    input  logic [HW_W-1:0]   launch_hw,
    input  logic [WAIT_W-1:0] cfg_wait,
    output logic              pend,
    output logic [WA_W-1:0]   pend_addr,
    output logic              pend_pf,
    output logic [HW_W-1:0]   pend_hw,
    output logic              done
);
    logic              pend_q;
    logic [WA_W-1:0]   addr_q;
    logic              pf_q;
    logic [HW_W-1:0]   hw_q;
    logic [WAIT_W-1:0] wait_q;
    logic [WAIT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            pf_q   <= 1'b0;
            hw_q   <= '0;
            wait_q <= WAIT_W'(1);
            cnt_q  <= WAIT_W'(1);
        end else if (launch) begin
            pend_q <= 1'b1;
            addr_q <= launch_addr;
            pf_q   <= launch_pf;
            hw_q   <= launch_hw;
            wait_q <= eff_wait(cfg_wait);
            cnt_q  <= WAIT_W'(1);
        end else if (done) begin
            pend_q <= 1'b0;
        end else if (pend_q) begin
            cnt_q <= cnt_q + WAIT_W'(1);
        end
    end

    assign pend      = pend_q;
    assign pend_addr = addr_q;
    assign pend_pf   = pf_q;
    assign pend_hw   = hw_q;
    assign done      = pend_q && (cnt_q == wait_q);

    p_wait_held_r8: assert property (@(posedge clk) disable iff (rst)
        (pend_q && !launch) |=> (wait_q == $past(wait_q)));

    p_count_bound_r8: assert property (@(posedge clk) disable iff (rst)
        pend_q |-> (cnt_q != '0 && cnt_q <= wait_q));

endmodule

// File: rtl/hwfb_word_buf.sv
module hwfb_word_buf import hwfb_pkg::*; #(
    parameter int WA_W = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              inval,
    input  logic [WA_W-1:0]   load_tag,
    input  logic [WORD_W-1:0] load_data,
    output logic              valid,
    output logic [WA_W-1:0]   tag,
    output logic [WORD_W-1:0] data
);
    logic              valid_q;
    logic [WA_W-1:0]   tag_q;
    logic [WORD_W-1:0] data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            data_q  <= '0;
        end else if (inval) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            tag_q   <= load_tag;
            data_q  <= load_data;
        end
    end

    assign valid = valid_q;
    assign tag   = tag_q;
    assign data  = data_q;

    p_discard_wins_r7: assert property (@(posedge clk) disable iff (rst)
        inval |=> !valid_q);

endmodule

// File: rtl/hw_fetch_buf.sv
module hw_fetch_buf import hwfb_pkg::*; #(
    parameter int ADDR_W = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [WAIT_W-1:0]   cfg_wait,
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    output logic [HALF_W-1:0]   req_data,
    output logic                fl_start,
    output logic [ADDR_W-3:0]   fl_addr,
    input  logic [WORD_W-1:0]   fl_data
);
    localparam int HW_W = ADDR_W - 1;
    localparam int WA_W = ADDR_W - 2;

    logic [HW_W-1:0]   req_hw;
    logic [WA_W-1:0]   req_word;
    logic              upper;
    logic              seq;

    logic              pend, pend_pf, rd_done;
    logic [WA_W-1:0]   pend_addr;
    logic [HW_W-1:0]   pend_hw;

    logic              buf_valid;
    logic [WA_W-1:0]   buf_tag;
    logic [WORD_W-1:0] buf_data;

    logic              pend_match;
    act_e              act;
    logic              launch;
    logic [WA_W-1:0]   launch_addr;
    logic [WORD_W-1:0] word_out;
    half_sel_t         out_sel;

    assign req_hw   = req_addr[ADDR_W-1:1];
    assign req_word = req_addr[ADDR_W-1:2];
    assign upper    = req_addr[1];

    hwfb_seq_track #(.HW_W(HW_W)) u_seq (
        .clk    (clk),
        .rst    (rst),
        .served (req_ready),
        .req_hw (req_hw),
        .seq    (seq)
    );

    assign pend_match = pend && (pend_addr == req_word) &&
                        (pend_pf ? seq : (pend_hw == req_hw));

    always_comb begin
        act = ACT_IDLE;
        if (req_valid) begin
            if (seq && buf_valid && (buf_tag == req_word))
                act = ACT_HIT;
            else if (pend_match)
                act = ACT_STALL;
            else
                act = ACT_MISS;
        end
    end

    assign req_ready = (act == ACT_HIT) || ((act == ACT_STALL) && rd_done);

    assign launch      = (act == ACT_MISS) || (req_ready && upper);
    assign launch_addr = (act == ACT_MISS) ? req_word : req_word + WA_W'(1);

    hwfb_read_ctrl #(.WA_W(WA_W), .HW_W(HW_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .launch      (launch),
        .launch_addr (launch_addr),
        .launch_pf   (act != ACT_MISS),
        .launch_hw   (req_hw),
        .cfg_wait    (cfg_wait),
        .pend        (pend),
        .pend_addr   (pend_addr),
        .pend_pf     (pend_pf),
        .pend_hw     (pend_hw),
        .done        (rd_done)
    );

    hwfb_word_buf #(.WA_W(WA_W)) u_buf (
        .clk       (clk),
        .rst       (rst),
        .load      (rd_done),
        .inval     (act == ACT_MISS),
        .load_tag  (pend_addr),
        .load_data (fl_data),
        .valid     (buf_valid),
        .tag       (buf_tag),
        .data      (buf_data)
    );

    assign word_out     = (act == ACT_HIT) ? buf_data : fl_data;
    assign out_sel.upper = upper;
    assign out_sel.half  = pick_half(word_out, upper);
    assign req_data     = out_sel.half;

    assign fl_start = launch;
    assign fl_addr  = launch_addr;

    p_ready_needs_valid_r10: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> req_valid);

    p_clean_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!buf_valid && !pend));

    p_upper_prefetch_r5: assert property (@(posedge clk) disable iff (rst)
        (req_ready && upper) |-> (fl_start && fl_addr == req_word + WA_W'(1)));

    p_miss_launch_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_ready && !pend_match) |-> (fl_start && fl_addr == req_word));

    p_hit_no_wait_r4: assert property (@(posedge clk) disable iff (rst)
        (req_valid && seq && upper && buf_valid && buf_tag == req_word) |-> req_ready);

endmodule

// File: tb/hw_fetch_buf_tb.sv
module hw_fetch_buf_tb;
    localparam int ADDR_W = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cfg_wait = 2'd1;
    logic        req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic        req_ready;
    logic [15:0] req_data;
    logic        fl_start;
    logic [ADDR_W-3:0] fl_addr;
    logic [31:0] fl_data;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    bit finished = 0;

    int m_last_hw = 0;
    bit m_last_v = 0;
    bit m_pf_v = 0;
    int m_pf_word = 0;
    int m_pf_rdy = 0;
    int cfg_now = 1;

    logic [ADDR_W-3:0] fa;
    int fc;

    always #4 clk = ~clk;

    hw_fetch_buf #(.ADDR_W(ADDR_W)) u_dut (
        .clk       (clk),
        .rst       (rst),
        .cfg_wait  (cfg_wait),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .req_data  (req_data),
        .fl_start  (fl_start),
        .fl_addr   (fl_addr),
        .fl_data   (fl_data)
    );

    function automatic int effw(input int c);
        return (c == 0) ? 1 : c;
    endfunction

    function automatic logic [31:0] memw(input int a);
        logic [15:0] lo, hi;
        lo = 16'(a ^ 16'hA5A5);
        hi = 16'(a * 3 + 16'h1111);
        return {hi, lo};
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst) fc <= 0;
        else if (fl_start) begin
            fa <= fl_addr;
            fc <= effw(int'(cfg_wait));
        end else if (fc > 0) fc <= fc - 1;
    end

    always_comb fl_data = (fc == 1) ? memw(int'(fa)) : 32'hBAD0_BAD0;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic setcfg(input int c);
        @(posedge clk); #1;
        cfg_now = c;
        cfg_wait = 2'(c);
    endtask

    task automatic idle(input int n);
        @(posedge clk); #1;
        req_valid = 1'b0;
        repeat (n - 1) @(posedge clk);
    endtask

    task automatic fetch(input int addr, input int newcfg);
        int hw, word, hs, t, expc;
        bit seq, fin;
        logic [31:0] w;
        hw = addr >> 1;
        word = addr >> 2;
        hs = hw & 1;
        @(posedge clk); #1;
        req_valid = 1'b1;
        req_addr = ADDR_W'(addr);
        t = cyc;
        seq = m_last_v && (hw == m_last_hw + 1);
        if (seq && hs == 1) expc = t;
        else if (seq && m_pf_v && m_pf_word == word) expc = (m_pf_rdy > t) ? m_pf_rdy : t;
        else begin
            seq = 0;
            expc = t + effw(cfg_now);
            m_pf_v = 0;
        end
        fin = 0;
        while (!fin) begin
            @(negedge clk);
            if (cyc == t && !seq)
                check(fl_start && int'(fl_addr) == word, "R3/R7 miss launch addr",
                      int'(fl_addr), word);
            check(req_ready == (cyc == expc), "R3/R4/R6/R8/R9 ready timing",
                  cyc, expc);
            if (req_ready) begin
                w = memw(word);
                check(req_data == (hs ? w[31:16] : w[15:0]), "R2/R10 halfword data",
                      int'(req_data), int'(hs ? w[31:16] : w[15:0]));
                if (hs) begin
                    check(fl_start && int'(fl_addr) == word + 1, "R5 prefetch next word",
                          int'(fl_addr), word + 1);
                    m_pf_v = 1;
                    m_pf_word = word + 1;
                    m_pf_rdy = cyc + effw(cfg_now);
                end
                m_last_hw = hw;
                m_last_v = 1;
                fin = 1;
            end else if (cyc > expc + 4) fin = 1;
            if (!fin) begin
                @(posedge clk); #1;
                if (newcfg >= 0) begin
                    cfg_now = newcfg;
                    cfg_wait = 2'(newcfg);
                end
            end
        end
    endtask

    task automatic run(input int base, input int n);
        for (int i = 0; i < n; i++) fetch(base + 2 * i, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (5) @(posedge clk);
        #1 rst = 1'b0;
        repeat (2) @(negedge clk);
        // R1: quiet after reset
        check(!req_ready && !fl_start, "R1 reset outputs", {req_ready, fl_start}, 0);
        // R1: first request to an upper halfword still misses
        setcfg(2);
        fetch(16'h0042, -1);
        idle(4);
        // R6 with W = 1, R2
        setcfg(1);
        run(16'h0000, 16);
        idle(3);
        // R6 with W = 2 and W = 3
        setcfg(2);
        run(16'h0100, 16);
        idle(3);
        setcfg(3);
        run(16'h0200, 16);
        idle(3);
        // R3, R5: miss on an upper halfword
        fetch(16'h0302, -1);
        fetch(16'h0304, -1);
        fetch(16'h0306, -1);
        idle(2);
        // R7: jump while a prefetch is in flight
        setcfg(2);
        fetch(16'h0400, -1);
        fetch(16'h0402, -1);
        fetch(16'h0500, -1);
        fetch(16'h0502, -1);
        fetch(16'h0504, -1);
        idle(2);
        // R7: repeated address whose word is buffered
        fetch(16'h0600, -1);
        fetch(16'h0600, -1);
        fetch(16'h0602, -1);
        idle(2);
        // R9: prefetch finishes while idle
        setcfg(3);
        fetch(16'h0700, -1);
        fetch(16'h0702, -1);
        idle(6);
        fetch(16'h0704, -1);
        fetch(16'h0706, -1);
        idle(2);
        // R8: zero setting behaves as one
        setcfg(0);
        run(16'h0800, 6);
        idle(2);
        // R8: change during an outstanding read
        setcfg(3);
        fetch(16'h0900, 1);
        fetch(16'h0902, -1);
        fetch(16'h0904, -1);
        // R2: bit 0 ignored
        fetch(16'h0907, -1);
        idle(3);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule